// File: doc/BRIEF.md
# Page-Table Capability Permission Checker

This block judges one page-table entry against one data access after the table walk has found it. The access is either a store or a load, and either plain data or a tagged capability. The block returns one of three verdicts. **Permit** lets the access go ahead. **Update** permits the access but first needs a single atomic write-back of the entry with the accessed, dirty and capability-dirty flags set. **Fault** blocks the access and gives a trap cause.

The capability-write, capability-dirty and capability-read flags are checked in a fixed order alongside the ordinary valid, privilege, write, accessed and dirty checks. A policy input picks between two behaviours when a flag is clear: raise a fault, or let hardware set the flag. In the 32-bit translation mode the capability flags are absent and count as granted.

The walk and the memory write are outside the block. The checker sits between them. A request accepted on one clock edge gets its registered verdict on the next edge.

Top module: `pte_cap_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid` is 0, `rsp_outcome` is 0, `rsp_cause` is 0 and `rsp_pte` is 0.
- R2: `rsp_valid` is high exactly in the cycle after `req_valid` was high. The verdict reflects the inputs sampled with that request.
- R3: Outcome encoding is 0 permit, 1 update, 2 fault, and `rsp_cause` is 0 unless the outcome is fault. A store faults with cause 15 when any of these holds: V (bit 0) is clear, W (bit 2) is set without R (bit 1), W is clear, or U (bit 4) differs from `req_user`. On a fault, or on permit, `rsp_pte` equals the input entry.
- R4: A tagged store through an entry whose capability-write flag (bit `CW_BIT`, default 61) is clear faults with cause 27. This happens under either policy, even when A (bit 6) or D (bit 7) is also clear, because this check comes before them.
- R5: An untagged store ignores the capability-write and capability-dirty flags. Those flags never cause a fault for it, and the capability-dirty bit is never written for it.
- R6: With `hw_dirty_update` low, a store that passes R3/R4 with A or D clear faults with cause 15. This takes precedence over a clear capability-dirty flag.
- R7: With `hw_dirty_update` low, a tagged store with capability-write, A and D set faults with cause 27 if capability-dirty (bit `CD_BIT`, default 60) is clear. Otherwise it is permitted.
- R8: With `hw_dirty_update` high, a store that passes R3/R4 returns update when any needed flag is clear. The needed flags are A, D, and, for tagged data only, capability-dirty. All missing flags are set together in one `rsp_pte`; every other bit is unchanged. When nothing is missing the outcome is permit.
- R9: When `sv32_mode` is high, the capability-write, capability-dirty and capability-read flags count as set. No cause 26 or 27 is produced, and capability-dirty is never written.
- R10: A load faults with cause 13 when V or R is clear, or when U differs from `req_user`.
- R11: A tagged load through a readable entry whose capability-read flag (bit `CR_BIT`, default 62) is clear faults with cause 26. This check comes before A. An untagged load ignores the flag.
- R12: A load that passes R10/R11 with A clear faults with cause 13 when `hw_dirty_update` is low. When it is high, the load returns update with only A set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_tag | input | 1 | Access carries a capability (tag asserted) |
| req_user | input | 1 | Access issued from user mode |
| hw_dirty_update | input | 1 | 1: hardware sets missing flags; 0: fault instead |
| sv32_mode | input | 1 | 32-bit translation mode, capability flags treated as set |
| pte_in | input | PTE_W | Page-table entry found by the walk |
| rsp_valid | output | 1 | Verdict valid |
| rsp_outcome | output | 2 | 0 permit, 1 update, 2 fault |
| rsp_cause | output | CAUSE_W | Trap cause on fault, else 0 |
| rsp_pte | output | PTE_W | Entry to write back on update, else the input entry |

## Verification
The bench targets the check ordering. A tagged store with capability-write clear and D clear must give cause 27, not 15. A tagged store with capability-dirty clear and D clear must give 15, not 27. A design with either priority swapped reports the wrong cause. The hardware-update cases check that A, D and capability-dirty are set together in a single entry and that no other bit moves. An implementation that sets capability-dirty for untagged data, or drops D on a capability store, produces a wrong entry. The 32-bit mode and untagged cases confirm that clear capability flags cause no fault. The tagged load with capability-read and A both clear confirms that cause 26 wins over 13.

// File: rtl/pte_cap_pkg.sv
package pte_cap_pkg;
  // Standard leaf-entry flag positions; a walker and other neighbours decode these.
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  localparam int CAUSE_W_INT        = 5;
  localparam int CAUSE_LOAD_PF      = 13;
  localparam int CAUSE_STORE_PF     = 15;
  localparam int CAUSE_CAP_LOAD_PF  = 26;
  localparam int CAUSE_CAP_STORE_PF = 27;

  typedef enum logic [1:0] {
    OUT_PERMIT = 2'd0,
    OUT_UPDATE = 2'd1,
    OUT_FAULT  = 2'd2
  } outcome_e;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic u;
    logic a;
    logic d;
    logic cw;
    logic cd;
    logic cr;
  } pte_flags_t;

  typedef struct packed {
    logic a;
    logic d;
    logic cd;
  } set_mask_t;

  typedef struct packed {
    outcome_e                 outcome;
    logic [CAUSE_W_INT-1:0]   cause;
    set_mask_t                set;
  } verdict_t;
endpackage

// File: rtl/pte_cap_decode.sv
module pte_cap_decode
  import pte_cap_pkg::*;
#(
  parameter int PTE_W    = 64,
  parameter int CW_BIT   = 61,
  parameter int CD_BIT   = 60,
  parameter int CR_BIT   = 62,
  parameter bit HAS_SV32 = 1'b1
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             sv32,
  output pte_flags_t       flags
);
  logic cap_force;

  generate
    if (HAS_SV32) begin : g_sv32
      assign cap_force = sv32;
    end else begin : g_no_sv32
      logic unused_sv32;
      assign unused_sv32 = sv32;
      assign cap_force   = 1'b0;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^pte;

  always_comb begin
    flags.v  = pte[BIT_V];
    flags.r  = pte[BIT_R];
    flags.w  = pte[BIT_W];
    flags.u  = pte[BIT_U];
    flags.a  = pte[BIT_A];
    flags.d  = pte[BIT_D];
    flags.cw = pte[CW_BIT] | cap_force;
    flags.cd = pte[CD_BIT] | cap_force;
    flags.cr = pte[CR_BIT] | cap_force;
  end
endmodule

// File: rtl/pte_cap_store_rules.sv
module pte_cap_store_rules
  import pte_cap_pkg::*;
(
  input  pte_flags_t flags,
  input  logic       tag,
  input  logic       user,
  input  logic       hw_update,
  output verdict_t   verdict
);
  logic base_bad, cap_bad, need_a, need_d, need_cd;
  logic unused_cr;
  assign unused_cr = flags.cr;

  always_comb begin
    base_bad = !flags.v || (flags.w && !flags.r) || !flags.w || (flags.u != user);
    cap_bad  = tag && !flags.cw;
    need_a   = !flags.a;
    need_d   = !flags.d;
    need_cd  = tag && !flags.cd;

    verdict.outcome = OUT_PERMIT;
    verdict.cause   = '0;
    verdict.set     = '0;

    if (base_bad) begin
      verdict.outcome = OUT_FAULT;
      verdict.cause   = CAUSE_W_INT'(CAUSE_STORE_PF);
    end else if (cap_bad) begin
      verdict.outcome = OUT_FAULT;
      verdict.cause   = CAUSE_W_INT'(CAUSE_CAP_STORE_PF);
    end else if (!hw_update) begin
      if (need_a || need_d) begin
        verdict.outcome = OUT_FAULT;
        verdict.cause   = CAUSE_W_INT'(CAUSE_STORE_PF);
      end else if (need_cd) begin
        verdict.outcome = OUT_FAULT;
        verdict.cause   = CAUSE_W_INT'(CAUSE_CAP_STORE_PF);
      end
    end else if (need_a || need_d || need_cd) begin
      verdict.outcome = OUT_UPDATE;
      verdict.set.a   = need_a;
      verdict.set.d   = need_d;
      verdict.set.cd  = need_cd;
    end
  end
endmodule

// File: rtl/pte_cap_load_rules.sv
module pte_cap_load_rules
  import pte_cap_pkg::*;
(
  input  pte_flags_t flags,
  input  logic       tag,
  input  logic       user,
  input  logic       hw_update,
  output verdict_t   verdict
);
  logic base_bad, cap_bad;
  logic unused_flags;
  assign unused_flags = flags.w ^ flags.d ^ flags.cw ^ flags.cd;

  always_comb begin
    base_bad = !flags.v || !flags.r || (flags.u != user);
    cap_bad  = tag && !flags.cr;

    verdict.outcome = OUT_PERMIT;
    verdict.cause   = '0;
    verdict.set     = '0;

    if (base_bad) begin
      verdict.outcome = OUT_FAULT;
      verdict.cause   = CAUSE_W_INT'(CAUSE_LOAD_PF);
    end else if (cap_bad) begin
      verdict.outcome = OUT_FAULT;
      verdict.cause   = CAUSE_W_INT'(CAUSE_CAP_LOAD_PF);
    end else if (!flags.a) begin
      if (hw_update) begin
        verdict.outcome = OUT_UPDATE;
        verdict.set.a   = 1'b1;
      end else begin
        verdict.outcome = OUT_FAULT;
        verdict.cause   = CAUSE_W_INT'(CAUSE_LOAD_PF);
      end
    end
  end
endmodule

// File: rtl/pte_cap_checker.sv
module pte_cap_checker
  import pte_cap_pkg::*;
#(
  parameter int PTE_W    = 64,
  parameter int CAUSE_W  = 6,
  parameter int CW_BIT   = 61,
  parameter int CD_BIT   = 60,
  parameter int CR_BIT   = 62,
  parameter bit HAS_SV32 = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_is_store,
  input  logic               req_tag,
  input  logic               req_user,
  input  logic               hw_dirty_update,
  input  logic               sv32_mode,
  input  logic [PTE_W-1:0]   pte_in,
  output logic               rsp_valid,
  output logic [1:0]         rsp_outcome,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [PTE_W-1:0]   rsp_pte
);
  pte_flags_t flags;
  verdict_t   st_verdict, ld_verdict, sel_verdict;
  logic [PTE_W-1:0] pte_next;

  pte_cap_decode #(
    .PTE_W(PTE_W), .CW_BIT(CW_BIT), .CD_BIT(CD_BIT), .CR_BIT(CR_BIT), .HAS_SV32(HAS_SV32)
  ) u_decode (
    .pte  (pte_in),
    .sv32 (sv32_mode),
    .flags(flags)
  );

  pte_cap_store_rules u_store (
    .flags    (flags),
    .tag      (req_tag),
    .user     (req_user),
    .hw_update(hw_dirty_update),
    .verdict  (st_verdict)
  );

  pte_cap_load_rules u_load (
    .flags    (flags),
    .tag      (req_tag),
    .user     (req_user),
    .hw_update(hw_dirty_update),
    .verdict  (ld_verdict)
  );

  always_comb begin
    sel_verdict = req_is_store ? st_verdict : ld_verdict;
    pte_next    = pte_in;
    if (sel_verdict.outcome == OUT_UPDATE) begin
      if (sel_verdict.set.a)  pte_next[BIT_A]  = 1'b1;
      if (sel_verdict.set.d)  pte_next[BIT_D]  = 1'b1;
      if (sel_verdict.set.cd) pte_next[CD_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= 2'd0;
      rsp_cause   <= '0;
      rsp_pte     <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_outcome <= sel_verdict.outcome;
      rsp_cause   <= CAUSE_W'(sel_verdict.cause);
      rsp_pte     <= pte_next;
    end
  end
endmodule

// File: rtl/pte_cap_checker_sva.sv
module pte_cap_checker_sva
  import pte_cap_pkg::*;
#(
  parameter int PTE_W    = 64,
  parameter int CAUSE_W  = 6,
  parameter int CD_BIT   = 60,
  parameter bit HAS_SV32 = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_is_store,
  input logic               req_tag,
  input logic               sv32_mode,
  input logic [PTE_W-1:0]   pte_in,
  input logic               rsp_valid,
  input logic [1:0]         rsp_outcome,
  input logic [CAUSE_W-1:0] rsp_cause,
  input logic [PTE_W-1:0]   rsp_pte
);
  localparam logic [CAUSE_W-1:0] C_CAP_ST = CAUSE_W'(CAUSE_CAP_STORE_PF);
  localparam logic [CAUSE_W-1:0] C_CAP_LD = CAUSE_W'(CAUSE_CAP_LOAD_PF);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome == 2'(OUT_FAULT)) |-> rsp_cause != '0); // R3
  AST_NOFAULT_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome != 2'(OUT_FAULT)) |-> rsp_cause == '0); // R3
  AST_PTE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome != 2'(OUT_UPDATE)) |-> rsp_pte == $past(pte_in)); // R3
  AST_UPDATE_ONLY_SETS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome == 2'(OUT_UPDATE)) |->
      (((rsp_pte & $past(pte_in)) == $past(pte_in)) && (rsp_pte != $past(pte_in)))); // R8
  AST_STORE_UPDATE_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome == 2'(OUT_UPDATE) && $past(req_is_store)) |-> rsp_pte[BIT_D]); // R8
  AST_UNTAGGED_NO_CAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_tag)) |-> (rsp_cause != C_CAP_ST && rsp_cause != C_CAP_LD)); // R5
  AST_UNTAGGED_CD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_tag)) |-> rsp_pte[CD_BIT] == $past(pte_in[CD_BIT])); // R5
  AST_SV32_NO_CAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (HAS_SV32 && rsp_valid && $past(sv32_mode)) |->
      (rsp_cause != C_CAP_ST && rsp_cause != C_CAP_LD)); // R9
endmodule

bind pte_cap_checker pte_cap_checker_sva #(
  .PTE_W(PTE_W), .CAUSE_W(CAUSE_W), .CD_BIT(CD_BIT), .HAS_SV32(HAS_SV32)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_is_store(req_is_store),
  .req_tag     (req_tag),
  .sv32_mode   (sv32_mode),
  .pte_in      (pte_in),
  .rsp_valid   (rsp_valid),
  .rsp_outcome (rsp_outcome),
  .rsp_cause   (rsp_cause),
  .rsp_pte     (rsp_pte)
);

// File: tb/pte_cap_checker_tb.sv
module pte_cap_checker_tb;
  localparam int PTE_W   = 64;
  localparam int CAUSE_W = 6;
  localparam int CW_B = 61, CD_B = 60, CR_B = 62;

  typedef struct packed {
    logic st, tag, usr, hw, s32;
    logic v, r, w, u, a, d, cw, cd, cr;
    logic [1:0] oc;
    logic [5:0] cause;
    logic sa, sd, scd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  //                st tag usr hw s32  v  r  w  u  a  d cw cd cr  oc cause sa sd scd req
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0, 0,1,1,0,1,1,1,1,1, 2,15, 0,0,0, 3},  // R3 V clear
    '{1,0,0,0,0, 1,1,0,0,1,1,1,1,1, 2,15, 0,0,0, 3},  // R3 W clear
    '{1,0,1,0,0, 1,1,1,0,1,1,1,1,1, 2,15, 0,0,0, 3},  // R3 user on supervisor page
    '{1,0,0,0,0, 1,0,1,0,1,1,1,1,1, 2,15, 0,0,0, 3},  // R3 W without R
    '{1,1,0,0,0, 1,1,1,0,0,0,0,0,1, 2,27, 0,0,0, 4},  // R4 CW before A/D
    '{1,1,0,1,0, 1,1,1,0,0,0,0,1,1, 2,27, 0,0,0, 4},  // R4 under update policy
    '{1,0,0,0,0, 1,1,1,0,1,1,0,0,1, 0, 0, 0,0,0, 5},  // R5 untagged ignores CW/CD
    '{1,0,0,1,0, 1,1,1,0,1,0,0,0,1, 1, 0, 0,1,0, 5},  // R5 untagged update no CD
    '{1,1,0,0,0, 1,1,1,0,1,0,1,0,1, 2,15, 0,0,0, 6},  // R6 D over CD
    '{1,1,0,0,0, 1,1,1,0,0,1,1,0,1, 2,15, 0,0,0, 6},  // R6 A over CD
    '{1,1,0,0,0, 1,1,1,0,1,1,1,0,1, 2,27, 0,0,0, 7},  // R7 CD clear
    '{1,1,0,0,0, 1,1,1,0,1,1,1,1,1, 0, 0, 0,0,0, 7},  // R7 all set
    '{1,1,0,1,0, 1,1,1,0,0,0,1,0,1, 1, 0, 1,1,1, 8},  // R8 set A, D, CD together
    '{1,1,0,1,0, 1,1,1,0,1,0,1,1,1, 1, 0, 0,1,0, 8},  // R8 D only
    '{1,1,0,0,1, 1,1,1,0,1,1,0,0,0, 0, 0, 0,0,0, 9},  // R9 sv32 store permit
    '{1,1,0,1,1, 1,1,1,0,1,0,0,0,0, 1, 0, 0,1,0, 9},  // R9 sv32 no CD write
    '{0,0,0,0,0, 1,0,0,0,1,1,1,1,1, 2,13, 0,0,0,10},  // R10 R clear
    '{0,0,1,0,0, 1,1,0,0,1,1,1,1,1, 2,13, 0,0,0,10},  // R10 privilege
    '{0,1,0,0,0, 1,1,0,0,0,1,1,1,0, 2,26, 0,0,0,11},  // R11 CR before A
    '{0,0,0,0,0, 1,1,0,0,1,1,1,1,0, 0, 0, 0,0,0,11},  // R11 untagged ignores CR
    '{0,0,0,0,0, 1,1,0,0,0,1,1,1,1, 2,13, 0,0,0,12},  // R12 A fault
    '{0,0,0,1,0, 1,1,0,0,0,1,1,1,1, 1, 0, 1,0,0,12},  // R12 A update
    '{0,1,0,0,1, 1,1,0,0,1,1,0,0,0, 0, 0, 0,0,0, 9},  // R9 sv32 load
    '{1,1,1,0,0, 1,1,1,1,1,1,1,1,1, 0, 0, 0,0,0, 3}   // R3 user page from user
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_is_store = 0, req_tag = 0, req_user = 0;
  logic hw_dirty_update = 0, sv32_mode = 0;
  logic [PTE_W-1:0] pte_in = '0;
  logic rsp_valid;
  logic [1:0] rsp_outcome;
  logic [CAUSE_W-1:0] rsp_cause;
  logic [PTE_W-1:0] rsp_pte;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pte_cap_checker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_tag(req_tag), .req_user(req_user), .hw_dirty_update(hw_dirty_update),
    .sv32_mode(sv32_mode), .pte_in(pte_in), .rsp_valid(rsp_valid),
    .rsp_outcome(rsp_outcome), .rsp_cause(rsp_cause), .rsp_pte(rsp_pte)
  );

  task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [PTE_W-1:0] build_pte(input vec_t t);
    logic [PTE_W-1:0] p;
    p = 64'h0000_00AB_CDE1_2300;
    p[0] = t.v; p[1] = t.r; p[2] = t.w; p[4] = t.u; p[6] = t.a; p[7] = t.d;
    p[CW_B] = t.cw; p[CD_B] = t.cd; p[CR_B] = t.cr;
    return p;
  endfunction

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 128'(rsp_valid), 128'(0));
    check("R1 outcome", 128'(rsp_outcome), 128'(0));
    check("R1 cause", 128'(rsp_cause), 128'(0));
    check("R1 pte", 128'(rsp_pte), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 128'(rsp_valid), 128'(0));

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic [PTE_W-1:0] p, e;
      string tagname;
      t = VECS[i];
      p = build_pte(t);
      e = p;
      if (t.sa)  e[6] = 1'b1;
      if (t.sd)  e[7] = 1'b1;
      if (t.scd) e[CD_B] = 1'b1;
      req_valid = 1; req_is_store = t.st; req_tag = t.tag; req_user = t.usr;
      hw_dirty_update = t.hw; sv32_mode = t.s32; pte_in = p;
      @(negedge clk);
      req_valid = 0;
      tagname = $sformatf("R%0d vec%0d", t.req, i);
      check({tagname, " valid"}, 128'(rsp_valid), 128'(1));
      check({tagname, " outcome"}, 128'(rsp_outcome), 128'(t.oc));
      check({tagname, " cause"}, 128'(rsp_cause), 128'(t.cause));
      check({tagname, " pte"}, 128'(rsp_pte), 128'(e));
    end

    // R2: no request, no response
    @(negedge clk);
    check("R2 idle", 128'(rsp_valid), 128'(0));

    // R2: back-to-back requests, each verdict one cycle later
    req_valid = 1; req_is_store = 1; req_tag = 1; req_user = 0; hw_dirty_update = 0;
    sv32_mode = 0; pte_in = build_pte(VECS[11]);
    @(negedge clk);
    check("R2 first", 128'(rsp_outcome), 128'(0));
    pte_in = build_pte(VECS[10]);
    @(negedge clk);
    req_valid = 0;
    check("R2 second valid", 128'(rsp_valid), 128'(1));
    check("R2 second cause", 128'(rsp_cause), 128'(27));
    @(negedge clk);
    check("R2 drop", 128'(rsp_valid), 128'(0));

    // R1: reset in mid-run clears outputs
    req_valid = 1; pte_in = build_pte(VECS[0]);
    @(negedge clk);
    rst = 1; req_valid = 0;
    @(negedge clk);
    check("R1 re-reset cause", 128'(rsp_cause), 128'(0));
    check("R1 re-reset valid", 128'(rsp_valid), 128'(0));
    rst = 0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule